// File: doc/BRIEF.md
# Selectable-Rate Square Wave and Periodic Interrupt Generator

This block counts a 32.768 kHz timebase, supplied as a one-cycle clock-enable, in a 15-bit binary divider. A 4-bit rate code picks one divider bit as the active tap. That tap drives a gated square-wave output and sets a sticky periodic flag on each of its rising edges. Software clears the flag with a read-clear strobe. The interrupt request is the flag qualified by an enable.

Because both outputs come from the same tap, the interrupt period always equals the square-wave period at a given code. The code-to-tap mapping is not monotonic. Two low codes repeat the 256 Hz and 128 Hz settings of two higher codes, and code 3 jumps to the fastest tap. Code 0 turns both functions off.

Top module: `rate_tap_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after its release, `sqw_o`, `flag_o` and `irq_o` are 0 and the divider holds 0.
- R2: The divider advances by exactly one on each clock where `tick_i` is 1 and holds otherwise, so a tap observed at the ports never changes on a clock without a tick.
- R3: With the divider count N, tap k is bit k of N, giving a frequency of 32768/2^(k+1) Hz. Codes 1 and 2 select bits 6 and 7 (256 Hz, 128 Hz), code 3 selects bit 1 (8.192 kHz), and codes 4 to 15 select bits 2 to 13 (4.096 kHz down to 2 Hz). The square-wave period in ticks is therefore 2^(k+1).
- R4: With code 0, `sqw_o` stays 0 and the flag is never set.
- R5: `sqw_o` is registered: one clock after an edge it equals `sqw_en_i` AND the selected tap. It is held at 0 while `sqw_en_i` is 0.
- R6: The flag is set on the same clock edge at which the selected tap rises, and stays set until cleared.
- R7: A 1 on `flag_clr_i` clears the flag at the next edge, unless a tap rise occurs at that same edge, in which case the flag ends up set.
- R8: `irq_o` is registered and equals the next flag value AND `pie_en_i`, so it is 0 whenever the enable is 0 and never 1 while the flag is 0.
- R9: A new rate code is sampled only on a tick. Until the next tick the outputs keep their value, and changing the code never resets the divider.
- R10: The flag is set by tap rises regardless of `sqw_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 32.768 kHz timebase clock-enable |
| rate_sel_i | input | 4 | Rate code choosing the divider tap |
| sqw_en_i | input | 1 | Square-wave output enable |
| pie_en_i | input | 1 | Periodic interrupt enable |
| flag_clr_i | input | 1 | Read-clear strobe for the periodic flag |
| sqw_o | output | 1 | Gated square wave |
| flag_o | output | 1 | Sticky periodic flag |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
A wrong divider count or a wrong tap index shows up as a square-wave period or phase error. That error is visible within one period of the selected tap, so up to 16384 ticks at the slowest code. A divider that is reset on a code change, instead of running on, is exposed at the first or second tick after the switch, when the new tap holds a value that a restarted count could not produce. Faults in the flag priority or the interrupt gating reach `flag_o` and `irq_o` one clock after the offending edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned RATE_W = 4;

  // divider bit driven out for a given rate code (code 0 is handled as "off")
  function automatic int unsigned rate_tap(input logic [RATE_W-1:0] code);
    case (code)
      4'd0:    return 32'd0;
      4'd1:    return 32'd6;
      4'd2:    return 32'd7;
      4'd3:    return 32'd1;
      default: return 32'(code) - 32'd2;
    endcase
  endfunction
endpackage

// File: rtl/rtg_divider.sv
module rtg_divider #(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic [STAGES-1:0] cnt_o,
  output logic [STAGES-1:0] cnt_nxt_o
);
  always_comb cnt_nxt_o = tick_i ? cnt_o + STAGES'(1) : cnt_o;

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_nxt_o;
  end

  // R2: one step per tick, frozen otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> cnt_o == $past(cnt_o) + STAGES'(1));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/rtg_tap_sel.sv
module rtg_tap_sel #(
  parameter int unsigned STAGES = 15,
  localparam int unsigned IDX_W = $clog2(STAGES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_i,
  input  logic [rtg_pkg::RATE_W-1:0] rate_i,
  input  logic [STAGES-1:0]          cnt_nxt_i,
  output logic                       tap_q_o,
  output logic                       tap_nxt_o,
  output logic                       rise_o
);
  int unsigned      idx_full;
  logic [IDX_W-1:0] idx;
  logic             sel_bit;

  always_comb begin
    idx_full  = rtg_pkg::rate_tap(rate_i);
    idx       = (idx_full < STAGES) ? IDX_W'(idx_full) : IDX_W'(STAGES - 1);
    sel_bit   = (rate_i != '0) && cnt_nxt_i[idx];
    tap_nxt_o = tick_i ? sel_bit : tap_q_o;
    rise_o    = tap_nxt_o && !tap_q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) tap_q_o <= 1'b0;
    else     tap_q_o <= tap_nxt_o;
  end

  // R9: code is only looked at on a tick
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(tap_q_o));
  // R4: code 0 keeps the tap low
  a_r4_off: assert property (@(posedge clk) disable iff (rst)
    (tick_i && rate_i == '0) |=> !tap_q_o);
endmodule

// File: rtl/rtg_flag.sv
module rtg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_nxt_o
);
  always_comb flag_nxt_o = set_i || (flag_o && !clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_nxt_o;
  end

  // R7: set beats clear, clear works alone
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R6: flag only rises on a tap rise
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    !set_i |=> !$rose(flag_o));
endmodule

// File: rtl/rate_tap_gen.sv
module rate_tap_gen #(
  parameter int unsigned STAGES = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [3:0] rate_sel_i,
  input  logic       sqw_en_i,
  input  logic       pie_en_i,
  input  logic       flag_clr_i,
  output logic       sqw_o,
  output logic       flag_o,
  output logic       irq_o
);
  logic [STAGES-1:0] cnt, cnt_nxt;
  logic tap_q, tap_nxt, rise, flag_nxt;

  rtg_divider #(.STAGES(STAGES)) u_div (
    .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt));

  rtg_tap_sel #(.STAGES(STAGES)) u_sel (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rate_i(rate_sel_i),
    .cnt_nxt_i(cnt_nxt), .tap_q_o(tap_q), .tap_nxt_o(tap_nxt), .rise_o(rise));

  rtg_flag u_flag (
    .clk(clk), .rst(rst), .set_i(rise), .clr_i(flag_clr_i),
    .flag_o(flag_o), .flag_nxt_o(flag_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      sqw_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      sqw_o <= sqw_en_i && tap_nxt;
      irq_o <= pie_en_i && flag_nxt;
    end
  end

  // R5: disabled square wave is low
  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    !sqw_en_i |=> !sqw_o);
  // R8: request needs the flag and the enable
  a_r8_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    !pie_en_i |=> !irq_o);
  // R1: outputs quiet right after reset
  a_r1_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!sqw_o && !flag_o && !irq_o));
endmodule

// File: tb/rate_tap_gen_tb.sv
module rate_tap_gen_tb;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [3:0] sel = '0;
  logic sqw_en = 1'b0, pie_en = 1'b0, clr = 1'b0;
  logic sqw, flag, irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rate_tap_gen u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .rate_sel_i(sel), .sqw_en_i(sqw_en),
    .pie_en_i(pie_en), .flag_clr_i(clr), .sqw_o(sqw), .flag_o(flag), .irq_o(irq));

  // log2 of expected period in ticks per code (0 = off)
  localparam int unsigned PLOG [16] = '{0, 7, 8, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(input int limit, output int clocks);
    logic prev;
    clocks = 0;
    forever begin
      prev = sqw;
      step(1);
      clocks++;
      if ((!prev && sqw) || clocks >= limit) break;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w, highs;
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 sqw", int'(sqw), 0);
    check("R1 flag", int'(flag), 0);
    check("R1 irq", int'(irq), 0);

    // R9/R2: count 6 ticks at code 3, switch codes without ticks
    sqw_en = 1'b1; sel = 4'd3; tick = 1'b1;
    step(6);
    tick = 1'b0;
    check("R2 bit1 of 6", int'(sqw), 1);
    sel = 4'd6;
    step(5);
    check("R9 hold until tick", int'(sqw), 1);
    sel = 4'd4; tick = 1'b1;
    step(1);
    check("R9 bit2 of 7 no divider reset", int'(sqw), 1);
    step(1);
    check("R9 bit2 of 8", int'(sqw), 0);

    // R3/R6/R7 table walk with a tick every clock
    for (int c = 1; c < 16; c++) begin
      sel = 4'(c);
      wait_rise(1 << 16, w);
      clr = 1'b1; step(1); clr = 1'b0;
      check("R7 clear", int'(flag), 0);
      wait_rise(1 << 16, w);
      check($sformatf("R3 period code %0d", c), w + 1, 1 << PLOG[c]);
      check($sformatf("R6 flag code %0d", c), int'(flag), 1);
    end

    // R4: code 0
    sel = 4'd0;
    step(2);
    clr = 1'b1; step(1); clr = 1'b0;
    highs = 0;
    for (int i = 0; i < 64; i++) begin step(1); if (sqw) highs++; end
    check("R4 sqw off", highs, 0);
    check("R4 flag off", int'(flag), 0);

    // R5/R10: square wave gated, flag still sets
    sel = 4'd3; sqw_en = 1'b0;
    step(2);
    highs = 0;
    for (int i = 0; i < 32; i++) begin step(1); if (sqw) highs++; end
    check("R5 gated low", highs, 0);
    check("R10 flag independent", int'(flag), 1);

    // R8: interrupt gating
    tick = 1'b0;
    step(1);
    check("R8 masked", int'(irq), 0);
    pie_en = 1'b1; step(1);
    check("R8 raised", int'(irq), 1);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R8 flag cleared", int'(flag), 0);
    check("R8 irq drops", int'(irq), 0);

    // R7: clear and rise at the same edge
    sqw_en = 1'b1; tick = 1'b1;
    wait_rise(64, w);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R7 plain clear", int'(flag), 0);
    step(2);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R7 set wins", int'(flag), 1);
    check("R7 rise edge", int'(sqw), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule